// File: doc/BRIEF.md
# Calibration Setting Serial Target

This block is the two-wire serial target that sits in front of a single 7-bit calibration setting, such as the trim code of a flicker-adjustment current sink. It samples the serial clock and data lines with the system clock, filters them, and finds START, repeated START and STOP conditions. When the first byte carries its address, it acknowledges by pulling the data line low through an open-drain enable.

A write transfer carries a second byte. Its upper seven bits are the new setting and its lowest bit is a mode flag. The flag chooses between a plain register update and a request to commit the value to non-volatile storage. Once the byte has been acknowledged, the block issues a one-cycle strobe together with the value and the decoded mode.

A read transfer returns the setting presented on the `cur_setting` input as one byte, most significant bit first. Only single-byte transfers are handled. The block does not stretch the clock, and it has no general-call or 10-bit address support.

Top module: `trim_i2c_target`

## Requirements
- R1: After reset, `sda_oe` is 0 and `wr_stb` is 0.
- R2: The block acknowledges (drives the ninth bit low) an address byte whose bits 7..2 are `100111`, for either value of bit 1. Bit 0 of that byte is the direction: 0 means write and 1 means read.
- R3: For any other address the block never drives the data line and issues no strobe. It ignores the rest of the transfer until the next START.
- R4: In a write, the setting is bits 7..1 of the second byte, sent most significant bit first. It appears on `wr_value` together with a `wr_stb` pulse.
- R5: Bit 0 of the second byte selects the mode. A 1 gives `wr_nvm`=0 (register-only update). A 0 gives `wr_nvm`=1 (non-volatile programming request).
- R6: The second byte of a write is acknowledged. `wr_stb` is issued only after that acknowledge clock has ended.
- R7: In a read, after the address acknowledge, the block shifts out `{cur_setting, 1'b0}` most significant bit first. It then releases the line for the controller's acknowledge bit.
- R8: A STOP before the second byte has been acknowledged aborts the write. No strobe follows, and the line is released.
- R9: A repeated START at any point restarts address reception, so a complete transfer that follows it behaves normally.
- R10: Each line must hold a new level for `FILT_LEN` consecutive system clocks before it is accepted. A 2-cycle pulse on the clock line is therefore ignored with the default `FILT_LEN`=3.
- R11: `wr_stb` is high for exactly one system clock per accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | Open-drain enable; 1 pulls the data line low |
| cur_setting | input | VAL_W | Setting returned by a read |
| wr_stb | output | 1 | One-cycle strobe for an accepted write |
| wr_value | output | VAL_W | Setting carried by the last accepted write |
| wr_nvm | output | 1 | 1 when the last write requested non-volatile programming |

## Verification
Several properties are checked on every cycle:
- the strobe lasts one cycle and coincides with the release of the data acknowledge;
- a STOP empties the protocol state and releases the line;
- a START always lands in address reception;
- the line is never driven while idle;
- filtered levels only follow a settled input;
- transmitted bits change only after a clock fall.

Other behaviour can only be shown by the bench's scenarios:
- address matching for both values of the don't-care bit;
- field extraction and mode decoding;
- the read byte's contents;
- aborts through STOP or repeated START;
- rejection of a short clock glitch.

The bench shows these with a reference queue of expected strobes that is compared on every clock.

// File: rtl/trim_i2c_pkg.sv
package trim_i2c_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK,
    ST_HOLD
  } trim_state_e;

  typedef struct packed {
    logic start;
    logic stop;
    logic scl_rise;
    logic scl_fall;
    logic sda;
  } bus_ev_t;

endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic line
);
  localparam int CNT_W = $clog2(FILT_LEN + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CNT_W-1:0]       run_q;
  logic                   synced;

  assign synced = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
      line   <= 1'b1;
      run_q  <= '0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
      if (synced == line) begin
        run_q <= '0;
      end else if (run_q == CNT_W'(FILT_LEN - 1)) begin
        line  <= synced;
        run_q <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  // R10: an accepted level equals what the synchronizer was presenting
  a_r10_settled_level: assert property (@(posedge clk) disable iff (rst)
    (line != $past(line)) |-> ($past(synced) == line));

endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events
  import trim_i2c_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    scl,
  input  logic    sda,
  output bus_ev_t ev
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  always_comb begin
    ev.start    = scl & scl_q & sda_q & ~sda;
    ev.stop     = scl & scl_q & ~sda_q & sda;
    ev.scl_rise = scl & ~scl_q;
    ev.scl_fall = ~scl & scl_q;
    ev.sda      = sda;
  end

endmodule

// File: rtl/trim_i2c_fsm.sv
module trim_i2c_fsm
  import trim_i2c_pkg::*;
#(
  parameter int              VAL_W     = 7,
  parameter int              ADDR_HI_W = 6,
  parameter logic [ADDR_HI_W-1:0] ADDR_HI = 6'b100111
) (
  input  logic             clk,
  input  logic             rst,
  input  bus_ev_t          ev,
  input  logic [VAL_W-1:0] cur_setting,
  output logic             sda_oe,
  output logic             wr_stb,
  output logic [VAL_W-1:0] wr_value,
  output logic             wr_nvm
);
  localparam int BYTE_W = VAL_W + 1;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  trim_state_e       state;
  logic [BYTE_W-1:0] rx_sh;
  logic [BYTE_W-1:0] tx_sh;
  logic [CNT_W-1:0]  bit_cnt;
  logic              is_read;
  logic              byte_done;
  logic              addr_hit;

  assign byte_done = (bit_cnt == CNT_W'(BYTE_W));
  assign addr_hit  = (rx_sh[BYTE_W-1 -: ADDR_HI_W] == ADDR_HI);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      rx_sh    <= '0;
      tx_sh    <= '0;
      bit_cnt  <= '0;
      is_read  <= 1'b0;
      sda_oe   <= 1'b0;
      wr_stb   <= 1'b0;
      wr_value <= '0;
      wr_nvm   <= 1'b0;
    end else begin
      wr_stb <= 1'b0;
      if (ev.start) begin
        state   <= ST_ADDR;
        bit_cnt <= '0;
        sda_oe  <= 1'b0;
      end else if (ev.stop) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR, ST_RX: begin
            if (ev.scl_rise && !byte_done) begin
              rx_sh   <= {rx_sh[BYTE_W-2:0], ev.sda};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (ev.scl_fall && byte_done) begin
              if (state == ST_RX) begin
                sda_oe <= 1'b1;
                state  <= ST_RX_ACK;
              end else if (addr_hit) begin
                sda_oe  <= 1'b1;
                is_read <= rx_sh[0];
                state   <= ST_ADDR_ACK;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (ev.scl_fall) begin
              bit_cnt <= '0;
              if (is_read) begin
                tx_sh  <= {cur_setting, 1'b0};
                sda_oe <= ~cur_setting[VAL_W-1];
                state  <= ST_TX;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_RX;
              end
            end
          end
          ST_RX_ACK: begin
            if (ev.scl_fall) begin
              sda_oe   <= 1'b0;
              wr_stb   <= 1'b1;
              wr_value <= rx_sh[BYTE_W-1:1];
              wr_nvm   <= ~rx_sh[0];
              state    <= ST_HOLD;
            end
          end
          ST_TX: begin
            if (ev.scl_rise) begin
              bit_cnt <= bit_cnt + 1'b1;
            end else if (ev.scl_fall) begin
              if (byte_done) begin
                sda_oe <= 1'b0;
                state  <= ST_TX_ACK;
              end else begin
                tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
                sda_oe <= ~tx_sh[BYTE_W-2];
              end
            end
          end
          ST_TX_ACK: begin
            if (ev.scl_rise) state <= ST_HOLD;
          end
          default: ;
        endcase
      end
    end
  end

  // R11: strobe lasts a single cycle
  a_r11_stb_single: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> !wr_stb);
  // R6: strobe comes with the release of the data acknowledge
  a_r6_stb_after_ack: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> $fell(sda_oe));
  // R8: a STOP clears the transfer and releases the line
  a_r8_stop_clears: assert property (@(posedge clk) disable iff (rst)
    ev.stop |=> (state == ST_IDLE && !sda_oe && !wr_stb));
  // R9: a START always restarts address reception
  a_r9_start_restarts: assert property (@(posedge clk) disable iff (rst)
    ev.start |=> (state == ST_ADDR && !sda_oe));
  // R3: idle never drives the line
  a_r3_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> !sda_oe);
  // R7: transmitted bits only change after a clock fall
  a_r7_tx_on_fall: assert property (@(posedge clk) disable iff (rst)
    (state == ST_TX && $past(state) == ST_TX && sda_oe != $past(sda_oe))
      |-> $past(ev.scl_fall));

endmodule

// File: rtl/trim_i2c_target.sv
module trim_i2c_target
  import trim_i2c_pkg::*;
#(
  parameter int VAL_W       = 7,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3,
  parameter int ADDR_HI_W   = 6,
  parameter logic [ADDR_HI_W-1:0] ADDR_HI = 6'b100111
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  input  logic [VAL_W-1:0] cur_setting,
  output logic             wr_stb,
  output logic [VAL_W-1:0] wr_value,
  output logic             wr_nvm
);
  localparam int N_LINES = 2;

  logic [N_LINES-1:0] raw_lines;
  logic [N_LINES-1:0] clean_lines;
  bus_ev_t            ev;

  assign raw_lines = {scl_i, sda_i};

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    i2c_line_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_LEN   (FILT_LEN)
    ) u_filt (
      .clk (clk),
      .rst (rst),
      .raw (raw_lines[g]),
      .line(clean_lines[g])
    );
  end

  i2c_bus_events u_events (
    .clk(clk),
    .rst(rst),
    .scl(clean_lines[1]),
    .sda(clean_lines[0]),
    .ev (ev)
  );

  trim_i2c_fsm #(
    .VAL_W    (VAL_W),
    .ADDR_HI_W(ADDR_HI_W),
    .ADDR_HI  (ADDR_HI)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .ev         (ev),
    .cur_setting(cur_setting),
    .sda_oe     (sda_oe),
    .wr_stb     (wr_stb),
    .wr_value   (wr_value),
    .wr_nvm     (wr_nvm)
  );

endmodule

// File: tb/tb_trim_i2c_target.sv
module tb_trim_i2c_target;
  localparam int Q = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl_drv = 1'b1;
  logic       sda_drv = 1'b1;
  logic       sda_oe;
  logic [6:0] cur_setting = 7'h00;
  logic       wr_stb;
  logic [6:0] wr_value;
  logic       wr_nvm;
  logic       sda_bus;

  int checks = 0;
  int fails  = 0;
  int strobes_seen = 0;
  bit done = 1'b0;
  bit prev_stb = 1'b0;
  logic [7:0] exp_q[$];

  assign sda_bus = sda_drv & ~sda_oe;

  always #4 clk = ~clk;

  trim_i2c_target dut (
    .clk(clk), .rst(rst), .scl_i(scl_drv), .sda_i(sda_bus), .sda_oe(sda_oe),
    .cur_setting(cur_setting), .wr_stb(wr_stb), .wr_value(wr_value), .wr_nvm(wr_nvm)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // per-clock reference comparison against the queue of expected strobes
  always @(negedge clk) begin
    if (!rst) begin
      if (wr_stb) begin
        strobes_seen++;
        check(!prev_stb, "R11", 1, 0);
        if (exp_q.size() == 0) begin
          check(1'b0, "R3/R8 unexpected strobe", {wr_value, wr_nvm}, 0);
        end else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          check(wr_value == e[7:1], "R4", wr_value, e[7:1]);
          check(wr_nvm == ~e[0], "R5", wr_nvm, ~e[0]);
        end
      end
      prev_stb = wr_stb;
    end
  end

  task automatic bus_start();
    sda_drv = 1'b1; waitc(Q);
    scl_drv = 1'b1; waitc(2*Q);
    sda_drv = 1'b0; waitc(2*Q);
    scl_drv = 1'b0; waitc(Q);
  endtask

  task automatic bus_stop();
    sda_drv = 1'b0; waitc(Q);
    scl_drv = 1'b1; waitc(2*Q);
    sda_drv = 1'b1; waitc(2*Q);
  endtask

  task automatic bit_io(input bit b, output bit seen);
    sda_drv = b;    waitc(Q);
    scl_drv = 1'b1; waitc(Q);
    seen = sda_bus; waitc(Q);
    scl_drv = 1'b0; waitc(Q);
  endtask

  task automatic send_byte(input logic [7:0] v, output bit ack, input int glitch_after);
    bit s;
    for (int i = 7; i >= 0; i--) begin
      bit_io(v[i], s);
      if (glitch_after == i) begin
        scl_drv = 1'b1; waitc(2);
        scl_drv = 1'b0; waitc(Q);
      end
    end
    bit_io(1'b1, ack);
  endtask

  task automatic recv_byte(output logic [7:0] v);
    bit s;
    for (int i = 7; i >= 0; i--) begin
      bit_io(1'b1, s);
      v[i] = s;
    end
    bit_io(1'b1, s);
  endtask

  task automatic do_write(input logic [7:0] addr, input logic [6:0] val, input bit p,
                          input string req, input int glitch_after);
    bit ack;
    bus_start();
    send_byte(addr, ack, -1);
    check(ack == 1'b0, "R2", ack, 0);
    exp_q.push_back({val, p});
    send_byte({val, p}, ack, glitch_after);
    check(ack == 1'b0, req, ack, 0);
    bus_stop();
    waitc(Q);
    check(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    bit ack;
    bit s;
    logic [7:0] rd;
    waitc(5);
    rst = 1'b0;
    waitc(2);
    // R1: reset state
    check(sda_oe == 1'b0, "R1", sda_oe, 0);
    check(wr_stb == 1'b0, "R1", wr_stb, 0);

    // R2, R4, R5, R6: register update, don't-care address bit at 0
    do_write(8'h9C, 7'h55, 1'b1, "R6", -1);
    // R2, R5: programming request, don't-care address bit at 1
    do_write(8'h9E, 7'h2A, 1'b0, "R6", -1);
    // R4 boundaries
    do_write(8'h9C, 7'h00, 1'b1, "R4", -1);
    do_write(8'h9E, 7'h7F, 1'b0, "R4", -1);

    // R7: read returns {setting, 0}
    cur_setting = 7'h5B;
    bus_start();
    send_byte(8'h9D, ack, -1);
    check(ack == 1'b0, "R2", ack, 0);
    recv_byte(rd);
    check(rd == 8'hB6, "R7", rd, 8'hB6);
    bus_stop();
    check(sda_oe == 1'b0, "R7", sda_oe, 0);
    cur_setting = 7'h01;
    bus_start();
    send_byte(8'h9F, ack, -1);
    recv_byte(rd);
    check(rd == 8'h02, "R7", rd, 8'h02);
    bus_stop();

    // R3: foreign address, no ack, data ignored
    bus_start();
    send_byte(8'h8C, ack, -1);
    check(ack == 1'b1, "R3", ack, 1);
    send_byte(8'h66, ack, -1);
    check(ack == 1'b1, "R3", ack, 1);
    bus_stop();
    waitc(Q);
    check(strobes_seen == 4, "R3", strobes_seen, 4);

    // R8: STOP in the middle of the data byte
    bus_start();
    send_byte(8'h9C, ack, -1);
    for (int i = 0; i < 4; i++) bit_io(1'b1, s);
    bus_stop();
    waitc(4*Q);
    check(strobes_seen == 4, "R8", strobes_seen, 4);
    check(sda_oe == 1'b0, "R8", sda_oe, 0);

    // R9: repeated START in the middle of the data byte, then full write
    bus_start();
    send_byte(8'h9C, ack, -1);
    for (int i = 0; i < 5; i++) bit_io(1'b0, s);
    do_write(8'h9C, 7'h11, 1'b1, "R9", -1);
    check(strobes_seen == 5, "R9", strobes_seen, 5);

    // R10: short clock glitch inside the data byte is ignored
    do_write(8'h9E, 7'h33, 1'b1, "R10", 3);
    check(strobes_seen == 6, "R10", strobes_seen, 6);

    waitc(Q);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule